// File: doc/BRIEF.md
# Write-Protect Command Detector

This block sits beside the page sequencer of a byte-wide nonvolatile memory. It sees each captured write as a one-cycle strobe with address and data. It keeps a persistent write-protect bit, and it tells the sequencer one cycle later whether that write's byte may be stored in the array. Two command chains are recognised. The first is a three-write unlock prefix, which opens the current load window for data even while protected and arms protection when that window closes. The second is a six-write chain that clears protection when the window closes. Command bytes are never stored.

The sequencer raises a load-window expiry pulse when the byte-load window closes and the programming cycle starts. That pulse ends the current page operation. It applies any pending change of the protect bit, and it abandons a partly entered command chain. A write made while protected and not unlocked is still reported as a write, so the sequencer runs its timer as a dummy busy cycle, but the store qualifier is low. The reset value of the protect bit is a parameter, which models the bit's nonvolatility across power cycles.

Top module: `wpd_top`

## Requirements
- R1: After synchronous reset, `prot_state` equals parameter `PROT_INIT` (default 0), `wr_vld` and `wr_store` are 0, and no command chain is in progress.
- R2: `wr_vld` is 1 in exactly the cycle after each cycle with `wr_evt` = 1. `wr_store` is valid in that same cycle and is 0 whenever `wr_vld` is 0.
- R3: Only address bits [14:0] take part in command matching. Bits [16:15] have no effect on matching.
- R4: The unlock prefix is data AAh at address 5555h, then 55h at 2AAAh, then A0h at 5555h, as consecutive writes. After it, every further write in the same load window has `wr_store` = 1, whatever the protect state.
- R5: When `win_expire` closes a window in which the prefix completed, `prot_state` is 1 from the cycle after the pulse. `prot_state` changes only on a `win_expire` cycle.
- R6: The disable chain is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h, as consecutive writes. When the window closes, `prot_state` becomes 0.
- R7: While `prot_state` = 1 and the window is not unlocked, every write gives `wr_vld` = 1 and `wr_store` = 0.
- R8: While `prot_state` = 0, a write that is not a command step gives `wr_store` = 1.
- R9: A write that does not match the next expected step returns the detector to idle. That write is treated as an ordinary write and is not re-tried as a first step.
- R10: `win_expire` abandons a partial chain and ends the unlock. When `win_expire` and `wr_evt` fall in the same cycle, the expiry is applied first and the write is judged against the new state.
- R11: If both chains complete within one window, the one completed last decides the protect state at expiry.
- R12: A write that matches the next expected step has `wr_store` = 0, even if the chain is broken later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_evt | input | 1 | One-cycle strobe for a captured write |
| wr_addr | input | ADDR_W (17) | Address of the captured write |
| wr_data | input | DATA_W (8) | Data of the captured write |
| win_expire | input | 1 | Load window closed; the page operation ends |
| wr_vld | output | 1 | Qualifier valid, one cycle after `wr_evt` |
| wr_store | output | 1 | The write's byte may be stored in the array |
| prot_state | output | 1 | Current write-protect state |

## Verification
A wrong chain position inside the detector shows at the ports at the write that follows. That write's `wr_store` differs from the model at once: a data byte is dropped, or a command byte is let through. A wrong unlock or pending flag stays hidden until the next `win_expire`. `prot_state` then takes the wrong value one cycle after the pulse, and every later write in the next window carries the wrong qualifier. For that reason the reference model is compared with the outputs on every clock, through chains that are broken, cut by expiry, and overlapped.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  // number of command bytes already matched in the current chain
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_X3   = 3'd3,
    ST_X4   = 3'd4,
    ST_X5   = 3'd5
  } step_e;

  typedef struct packed {
    logic  hit;      // write matches the next expected step
    logic  unlock;   // prefix completed
    logic  disarm;   // disable chain completed
    step_e nxt;      // chain position after this write
  } match_t;
endpackage

// File: rtl/wpd_match.sv
module wpd_match
  import wpd_pkg::*;
#(
  parameter int          CMP_W  = 15,
  parameter int          DATA_W = 8,
  parameter logic [14:0] ADDR_A = 15'h5555,
  parameter logic [14:0] ADDR_B = 15'h2AAA,
  parameter logic [7:0]  D_K1   = 8'hAA,
  parameter logic [7:0]  D_K2   = 8'h55,
  parameter logic [7:0]  D_UNL  = 8'hA0,
  parameter logic [7:0]  D_EXT  = 8'h80,
  parameter logic [7:0]  D_DIS  = 8'h20
) (
  input  step_e             step,
  input  logic [CMP_W-1:0]  addr,
  input  logic [DATA_W-1:0] data,
  output match_t            res
);
  localparam logic [CMP_W-1:0]  CA = CMP_W'(ADDR_A);
  localparam logic [CMP_W-1:0]  CB = CMP_W'(ADDR_B);
  localparam logic [DATA_W-1:0] K1 = DATA_W'(D_K1);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(D_K2);
  localparam logic [DATA_W-1:0] UN = DATA_W'(D_UNL);
  localparam logic [DATA_W-1:0] EX = DATA_W'(D_EXT);
  localparam logic [DATA_W-1:0] DS = DATA_W'(D_DIS);

  logic at_a, at_b;
  assign at_a = (addr == CA);
  assign at_b = (addr == CB);

  always_comb begin
    res     = '0;
    res.nxt = ST_IDLE;
    unique case (step)
      ST_IDLE: if (at_a && data == K1) begin res.hit = 1'b1; res.nxt = ST_K1; end
      ST_K1:   if (at_b && data == K2) begin res.hit = 1'b1; res.nxt = ST_K2; end
      ST_K2: begin
        if (at_a && data == UN) begin
          res.hit = 1'b1; res.unlock = 1'b1; res.nxt = ST_IDLE;
        end else if (at_a && data == EX) begin
          res.hit = 1'b1; res.nxt = ST_X3;
        end
      end
      ST_X3:   if (at_a && data == K1) begin res.hit = 1'b1; res.nxt = ST_X4; end
      ST_X4:   if (at_b && data == K2) begin res.hit = 1'b1; res.nxt = ST_X5; end
      ST_X5:   if (at_a && data == DS) begin res.hit = 1'b1; res.disarm = 1'b1; res.nxt = ST_IDLE; end
      default: ;
    endcase
  end
endmodule

// File: rtl/wpd_seq.sv
module wpd_seq
  import wpd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_evt,
  input  logic   win_expire,
  input  match_t res,
  output step_e  step_eff,   // chain position the current write is judged against
  output logic   unl_eff,    // window unlocked, as seen by the current write
  output logic   cmd_hit,    // current write is a command byte
  output logic   en_q,
  output logic   dis_q
);
  step_e step_q, step_n;
  logic  unl_q, unl_n, en_n, dis_n;
  logic  en_b, dis_b;

  // expiry is applied before the write of the same cycle (R10)
  always_comb begin
    step_eff = win_expire ? ST_IDLE : step_q;
    unl_eff  = win_expire ? 1'b0 : unl_q;
    en_b     = win_expire ? 1'b0 : en_q;
    dis_b    = win_expire ? 1'b0 : dis_q;
    cmd_hit  = wr_evt && !unl_eff && res.hit;
    step_n   = step_eff;
    unl_n    = unl_eff;
    en_n     = en_b;
    dis_n    = dis_b;
    if (wr_evt && !unl_eff) begin
      if (res.hit) begin
        step_n = res.nxt;
        if (res.unlock) begin unl_n = 1'b1; en_n = 1'b1; dis_n = 1'b0; end
        if (res.disarm) begin dis_n = 1'b1; en_n = 1'b0; end   // last chain wins (R11)
      end else begin
        step_n = ST_IDLE;                                       // mismatch -> idle (R9)
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      unl_q  <= 1'b0;
      en_q   <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      step_q <= step_n;
      unl_q  <= unl_n;
      en_q   <= en_n;
      dis_q  <= dis_n;
    end
  end

  p_step_legal_r9: assert property (@(posedge clk) disable iff (rst)
    $unsigned(step_q) <= 3'd5);
  p_unlock_ends_r10: assert property (@(posedge clk) disable iff (rst)
    (win_expire && !wr_evt) |=> (!unl_q && step_q == ST_IDLE));
  p_pend_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(en_q && dis_q));
endmodule

// File: rtl/wpd_prot.sv
module wpd_prot #(
  parameter logic PROT_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic en_q,
  input  logic dis_q,
  output logic prot_q,
  output logic prot_eff
);
  logic prot_n;

  always_comb begin
    prot_n = prot_q;
    if (en_q)       prot_n = 1'b1;
    else if (dis_q) prot_n = 1'b0;
    prot_eff = commit ? prot_n : prot_q;
  end

  // reset value models the retained nonvolatile bit
  always_ff @(posedge clk) begin
    if (rst)         prot_q <= PROT_INIT;
    else if (commit) prot_q <= prot_n;
  end

  p_prot_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(prot_q));
  p_prot_arm_r5: assert property (@(posedge clk) disable iff (rst)
    (commit && en_q) |=> prot_q);
  p_prot_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (commit && dis_q) |=> !prot_q);
endmodule

// File: rtl/wpd_top.sv
module wpd_top
  import wpd_pkg::*;
#(
  parameter int   ADDR_W    = 17,
  parameter int   DATA_W    = 8,
  parameter int   CMP_W     = 15,
  parameter logic PROT_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_expire,
  output logic              wr_vld,
  output logic              wr_store,
  output logic              prot_state
);
  localparam int HI_W = ADDR_W - CMP_W;

  step_e  step_eff;
  match_t res;
  logic   unl_eff, cmd_hit, en_q, dis_q, prot_eff, store_c;

  // upper address bits are don't-care for command matching (R3)
  generate
    if (HI_W > 0) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_addr[ADDR_W-1:CMP_W];
    end
  endgenerate

  wpd_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
    .step (step_eff),
    .addr (wr_addr[CMP_W-1:0]),
    .data (wr_data),
    .res  (res)
  );

  wpd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_evt     (wr_evt),
    .win_expire (win_expire),
    .res        (res),
    .step_eff   (step_eff),
    .unl_eff    (unl_eff),
    .cmd_hit    (cmd_hit),
    .en_q       (en_q),
    .dis_q      (dis_q)
  );

  wpd_prot #(.PROT_INIT(PROT_INIT)) u_prot (
    .clk      (clk),
    .rst      (rst),
    .commit   (win_expire),
    .en_q     (en_q),
    .dis_q    (dis_q),
    .prot_q   (prot_state),
    .prot_eff (prot_eff)
  );

  assign store_c = !cmd_hit && (!prot_eff || unl_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_vld   <= 1'b0;
      wr_store <= 1'b0;
    end else begin
      wr_vld   <= wr_evt;
      wr_store <= wr_evt && store_c;
    end
  end

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> wr_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> (!wr_vld && !wr_store));
  p_cmd_dropped_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && res.hit && !unl_eff) |=> !wr_store);
  p_dummy_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && prot_state && !win_expire && !unl_eff) |=> (wr_vld && !wr_store));
endmodule

// File: tb/wpd_top_test.sv
module wpd_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic PINIT = 1'b0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_evt = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        win_expire = 1'b0;
  logic        wr_vld, wr_store, prot_state;

  int    checks = 0;
  int    failures = 0;
  string tag = "R1";
  bit    started = 0;

  // reference model state
  int unsigned m_step;
  bit m_unl, m_en, m_dis, m_prot, e_vld, e_store;
  logic [14:0] ch_a [6];
  logic [7:0]  ch_d [6];

  wpd_top #(.PROT_INIT(PINIT)) uut (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_expire(win_expire), .wr_vld(wr_vld), .wr_store(wr_store), .prot_state(prot_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    ch_a[0] = 15'h5555; ch_d[0] = 8'hAA;
    ch_a[1] = 15'h2AAA; ch_d[1] = 8'h55;
    ch_a[2] = 15'h5555; ch_d[2] = 8'h80;
    ch_a[3] = 15'h5555; ch_d[3] = 8'hAA;
    ch_a[4] = 15'h2AAA; ch_d[4] = 8'h55;
    ch_a[5] = 15'h5555; ch_d[5] = 8'h20;
  end

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    bit st;
    started = 1;
    if (rst) begin
      m_step = 0; m_unl = 0; m_en = 0; m_dis = 0; m_prot = PINIT;
      e_vld = 0; e_store = 0;
    end else begin
      if (win_expire) begin
        if (m_en) m_prot = 1; else if (m_dis) m_prot = 0;
        m_step = 0; m_unl = 0; m_en = 0; m_dis = 0;
      end
      st = 0;
      if (wr_evt) begin
        if (m_unl) st = 1;
        else if (m_step == 2 && wr_addr[14:0] == 15'h5555 && wr_data == 8'hA0) begin
          m_unl = 1; m_en = 1; m_dis = 0; m_step = 0; st = 0;
        end else if (wr_addr[14:0] == ch_a[m_step] && wr_data == ch_d[m_step]) begin
          m_step++; st = 0;
          if (m_step == 6) begin m_dis = 1; m_en = 0; m_step = 0; end
        end else begin
          m_step = 0; st = !m_prot;
        end
      end
      e_vld = wr_evt; e_store = wr_evt && st;
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) if (started) begin
    chk(tag, "wr_vld (R2)", int'(wr_vld), int'(e_vld));
    chk(tag, "wr_store", int'(wr_store), int'(e_store));
    chk(tag, "prot_state", int'(prot_state), int'(m_prot));
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit exp_store);
    @(negedge clk); wr_evt = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_evt = 0;
    chk(tag, "directed store", int'(wr_store), int'(exp_store));
  endtask
  task automatic expire(input bit exp_prot);
    @(negedge clk); win_expire = 1;
    @(negedge clk); win_expire = 0;
    chk(tag, "prot after expiry", int'(prot_state), int'(exp_prot));
  endtask
  task automatic prefix(input logic [1:0] hi);
    wr({hi, 15'h5555}, 8'hAA, 0);
    wr({hi, 15'h2AAA}, 8'h55, 0);
    wr({hi, 15'h5555}, 8'hA0, 0);
  endtask
  task automatic disarm();
    for (int i = 0; i < 6; i++) wr({2'b00, ch_a[i]}, ch_d[i], 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    chk(tag, "reset prot", int'(prot_state), int'(PINIT));
    chk(tag, "reset vld", int'(wr_vld), 0);
    tag = "R8";
    wr(17'h00123, 8'h3C, 1);
    wr(17'h1F0F0, 8'hAA, 1);
    tag = "R12";
    wr(17'h05555, 8'hAA, 0);
    tag = "R9";
    wr(17'h00010, 8'h77, 1);        // breaks chain, ordinary
    wr(17'h05555, 8'hAA, 0);
    wr(17'h05555, 8'hAA, 1);        // mismatch at step 1, not re-tried
    wr(17'h02AAA, 8'h55, 1);
    expire(0);
    tag = "R4";
    prefix(2'b00);
    wr(17'h00400, 8'h11, 1);
    wr(17'h05555, 8'hAA, 1);        // data once unlocked
    tag = "R5";
    expire(1);
    tag = "R7";
    wr(17'h00400, 8'h22, 0);
    wr(17'h00401, 8'h23, 0);
    expire(1);
    tag = "R4";
    prefix(2'b00);
    wr(17'h00500, 8'h44, 1);
    expire(1);
    tag = "R3";
    prefix(2'b11);
    wr(17'h18000, 8'h66, 1);
    expire(1);
    tag = "R9";
    wr(17'h05555, 8'hAA, 0);
    wr(17'h05555, 8'hAA, 0);
    wr(17'h02AAA, 8'h55, 0);
    wr(17'h05555, 8'hA0, 0);
    wr(17'h00600, 8'h99, 0);        // still locked
    expire(1);
    tag = "R10";
    wr(17'h05555, 8'hAA, 0);
    wr(17'h02AAA, 8'h55, 0);
    expire(1);
    wr(17'h05555, 8'hA0, 0);
    wr(17'h00700, 8'h01, 0);
    expire(1);
    prefix(2'b00);
    @(negedge clk); win_expire = 1; wr_evt = 1; wr_addr = 17'h00800; wr_data = 8'h02;
    @(negedge clk); win_expire = 0; wr_evt = 0;
    chk(tag, "write with expiry judged after", int'(wr_store), 0);
    tag = "R6";
    disarm();
    expire(0);
    wr(17'h00900, 8'h03, 1);
    tag = "R11";
    disarm();
    prefix(2'b00);
    expire(1);
    prefix(2'b00);
    wr(17'h00A00, 8'h04, 1);
    expire(1);
    disarm();
    expire(0);
    tag = "R2";
    @(negedge clk); wr_evt = 1; wr_addr = 17'h00B00; wr_data = 8'h05;
    @(negedge clk); wr_addr = 17'h00B01;
    @(negedge clk); wr_evt = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    rst = 1;
    @(negedge clk); rst = 0;
    chk(tag, "reset after use", int'(prot_state), int'(PINIT));
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule